// File: doc/BRIEF.md
# I2C Target Read-Data Transmitter

This block is the target side of an I2C bus for read transfers. It watches the bus for a start condition and shifts in the first byte. The upper seven bits of that byte are compared with a host-programmed own address. On a match it answers on the ninth clock with a host-chosen acknowledge level. When the direction bit asks for a read, it moves into transmit mode by itself and sends bytes that the host supplies one at a time through a transmit data register.

The host side is a set of single-cycle strobes (write data, clear flags, read the receive register) and three status flags:

- **transmit-empty** means a new byte may be written.
- **transmit-end** means the last byte went out with nothing queued.
- **transmit-mode** means the block is sending.

The block holds SCL low whenever it cannot continue:

- at the start of a byte while no data is queued;
- after the final byte, until the host has left transmit mode and done a dummy read of the receive register.

Both bus pins are open-drain. The block only ever pulls a line low or lets it go. Both inputs pass through a two-flop synchronizer before edge detection.

Top module: `i2c_tgt_tx`

## Requirements
- R1: After reset, the transmit-empty flag `tdre`, the transmit-end flag `tend` and the transmit-mode flag `trs` are 0, and neither bus line is pulled low (`scl_oe` = 0, `sda_oe` = 0).
- R2: The address byte is made of bits 7..1 (own address) and bit 0 (direction, 1 = read), received MSB first. On a match the block pulls SDA low during the ninth clock when `ack_level` = 0 and leaves SDA released when `ack_level` = 1. On a mismatch it leaves SDA released.
- R3: A matching address with direction 1 and `ack_level` = 0 sets `trs` and `tdre` with no host action. Any other address byte leaves `trs` at 0.
- R4: Data bytes appear on SDA MSB first (bit 7 down to bit 0), one bit per SCL clock. SDA changes only while SCL is low.
- R5: The `tdre` flag works as follows:
  - A host write (`wr_tdr`) clears it.
  - It is set again when the byte moves into the shift register.
  - A `clr_tdre` strobe clears it.
  - The register is never taken while `tdre` is 1.
- R6: When a byte is due and the transmit register is empty, SCL stays low until the host writes a byte. It is released a few cycles after that write.
- R7: The `tend` flag is set at the end of the ninth clock of a data byte if `tdre` is 1 at that time. A `clr_tend` strobe clears it. If the set and the clear fall in the same cycle, the set wins.
- R8: Once SCL is held after a byte, it is released to end the transfer only by an `rd_rdr` strobe that arrives while `trs` is 0. Neither an `rd_rdr` strobe with `trs` = 1 nor a `clr_trs` alone releases it. `rdr_data` holds the matched address byte.
- R9: A NACK from the master ends the sending and leaves SDA released. A stop condition returns the block to waiting for an address, and the next start is decoded afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Block enable; when low the engine idles and releases the bus |
| own_addr | input | 7 | Programmed own address |
| ack_level | input | 1 | Acknowledge level for a matching address (0 = ACK) |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| wr_tdr | input | 1 | Strobe: write `wr_data` into the transmit register |
| wr_data | input | 8 | Transmit byte |
| clr_tdre | input | 1 | Strobe: clear the transmit-empty flag |
| clr_tend | input | 1 | Strobe: clear the transmit-end flag |
| clr_trs | input | 1 | Strobe: leave transmit mode |
| rd_rdr | input | 1 | Strobe: read of the receive register |
| rdr_data | output | 8 | Receive register (last matched address byte) |
| tdre | output | 1 | Transmit register empty |
| tend | output | 1 | Transmit end |
| trs | output | 1 | Transmit mode |

## Verification
Two events can land in the same clock: the engine setting the transmit-end flag when the ninth clock of the last byte falls, and the host clearing that flag. The bench provokes this collision on purpose:

- It pulls SCL low for the final NACK clock on a falling system-clock edge.
- It counts the two synchronizer stages and the edge-detect register.
- It raises `clr_tend` for exactly the cycle in which the set lands.

The flag must read 1 afterwards, because the set wins. A later, separate clear must then bring it to 0.

// File: rtl/i2c_tgt_pkg.sv
// Package: shared state encoding for the I2C target transmitter.
// Assumes: byte-wide data on the bus.
package i2c_tgt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,     // waiting for a start condition
        ST_ADDR,     // shifting in the address byte
        ST_AACK,     // driving the address acknowledge
        ST_STRETCH,  // holding SCL low, waiting on the host
        ST_SETUP,    // SDA driven with bit 7, SCL still held one cycle
        ST_TXBIT,    // shifting out data bits
        ST_TXACK,    // sampling the master acknowledge
        ST_WSTOP     // bus released, waiting for a stop
    } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
// Module: two-line input synchronizer with bus event detection.
// What it does: brings SCL and SDA into the clock domain through STAGES
//   flops and flags SCL edges plus start and stop conditions.
// Assumes: STAGES >= 2; the idle bus level is high.
module i2c_tgt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] lvl;
    logic [NLINES-1:0] prev_q;

    assign raw = {sda_i, scl_i};

    genvar g;
    generate
        for (g = 0; g < NLINES; g++) begin : g_line
            logic [STAGES-1:0] q;
            // Shift the raw line level through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= '1;
                else        q <= {q[STAGES-2:0], raw[g]};
            end
            assign lvl[g] = q[STAGES-1];
        end
    endgenerate

    // Keep the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= lvl;
    end

    assign scl_s     = lvl[0];
    assign sda_s     = lvl[1];
    assign scl_rise  = lvl[0] & ~prev_q[0];
    assign scl_fall  = ~lvl[0] & prev_q[0];
    assign bus_start = lvl[0] & prev_q[0] & prev_q[1] & ~lvl[1];
    assign bus_stop  = lvl[0] & prev_q[0] & ~prev_q[1] & lvl[1];
endmodule

// File: rtl/i2c_tgt_regs.sv
// Module: host-side registers and status flags of the I2C target.
// What it does: holds the transmit and receive registers and the
//   transmit-empty, transmit-end and transmit-mode flags. It also forms the
//   end-processing release request (dummy read with transmit mode off).
// Assumes: host strobes are single-cycle; engine event pulses come from
//   the bit engine in the same clock domain.
module i2c_tgt_regs #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_tdr,
    input  logic [DW-1:0] wr_data,
    input  logic          clr_tdre,
    input  logic          clr_tend,
    input  logic          clr_trs,
    input  logic          rd_rdr,
    input  logic          go_tx,
    input  logic          load,
    input  logic          byte_done,
    input  logic          addr_cap,
    input  logic [DW-1:0] addr_byte,
    output logic [DW-1:0] tdr,
    output logic [DW-1:0] rdr,
    output logic          tdre,
    output logic          tend,
    output logic          trs,
    output logic          rel_req
);
    // Transmit register: captured on every host write.
    always_ff @(posedge clk) begin
        if (!rst_n)      tdr <= '0;
        else if (wr_tdr) tdr <= wr_data;
    end

    // Receive register: takes the address byte on a match.
    always_ff @(posedge clk) begin
        if (!rst_n)        rdr <= '0;
        else if (addr_cap) rdr <= addr_byte;
    end

    // Empty flag: a host write wins, then engine set, then host clear.
    always_ff @(posedge clk) begin
        if (!rst_n)               tdre <= 1'b0;
        else if (wr_tdr)          tdre <= 1'b0;
        else if (go_tx || load)   tdre <= 1'b1;
        else if (clr_tdre)        tdre <= 1'b0;
    end

    // End flag: set at a byte end with nothing queued; set beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                 tend <= 1'b0;
        else if (byte_done && tdre) tend <= 1'b1;
        else if (clr_tend)          tend <= 1'b0;
    end

    // Transmit-mode flag: set by a read address match, cleared by host.
    always_ff @(posedge clk) begin
        if (!rst_n)       trs <= 1'b0;
        else if (go_tx)   trs <= 1'b1;
        else if (clr_trs) trs <= 1'b0;
    end

    assign rel_req = rd_rdr & ~trs;

    assert_tend_from_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tend) |-> $past(byte_done));
    assert_trs_from_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trs) |-> $past(go_tx));
endmodule

// File: rtl/i2c_tgt_fsm.sv
// Module: bit engine of the I2C target transmitter.
// What it does: decodes the address byte, drives the acknowledge, and
//   shifts out data MSB first. It samples the master acknowledge and
//   holds SCL low while the host has work to do.
// Assumes: inputs are already synchronized; the master keeps SCL low for
//   several system clocks per phase, longer than the detect latency.
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [DW-2:0] own_addr,
    input  logic          ack_level,
    input  logic          scl_s,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          bus_start,
    input  logic          bus_stop,
    input  logic [DW-1:0] tdr,
    input  logic          tdre,
    input  logic          trs,
    input  logic          rel_req,
    output logic          go_tx,
    output logic          load,
    output logic          byte_done,
    output logic          addr_cap,
    output logic [DW-1:0] addr_byte,
    output logic          scl_low,
    output logic          sda_low
);
    localparam int CW = $clog2(DW + 1);

    tgt_state_e    state;
    logic [DW-1:0] sh;
    logic [CW-1:0] cnt;
    logic          is_rd;
    logic          mack;
    logic          addr_end;
    logic          match;
    logic          can_load;

    // Event pulses handed to the register block.
    always_comb begin
        addr_end  = (state == ST_ADDR) && scl_fall && (cnt == CW'(DW));
        match     = (sh[DW-1:1] == own_addr);
        addr_cap  = addr_end && match;
        go_tx     = addr_cap && sh[0] && !ack_level;
        can_load  = trs && !tdre && mack;
        load      = ((state == ST_TXACK) && scl_fall && can_load) ||
                    ((state == ST_STRETCH) && can_load);
        byte_done = (state == ST_TXACK) && scl_fall;
    end

    assign addr_byte = sh;
    assign scl_low   = (state == ST_STRETCH) || (state == ST_SETUP);

    // Main sequencer: bus conditions first, then per-state bit handling.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            state   <= ST_IDLE;
            sh      <= '0;
            cnt     <= '0;
            is_rd   <= 1'b0;
            mack    <= 1'b0;
            sda_low <= 1'b0;
        end else if (bus_stop) begin
            state   <= ST_IDLE;
            sda_low <= 1'b0;
        end else if (bus_start) begin
            state   <= ST_ADDR;
            cnt     <= '0;
            sda_low <= 1'b0;
        end else begin
            case (state)
                ST_ADDR: begin
                    if (scl_rise) begin
                        sh  <= {sh[DW-2:0], sda_s};
                        cnt <= cnt + 1'b1;
                    end else if (addr_end) begin
                        if (match) begin
                            sda_low <= ~ack_level;
                            is_rd   <= go_tx;
                            state   <= ST_AACK;
                        end else begin
                            state   <= ST_WSTOP;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        sda_low <= 1'b0;
                        mack    <= 1'b1;
                        state   <= is_rd ? ST_STRETCH : ST_WSTOP;
                    end
                end
                ST_STRETCH: begin
                    if (load) begin
                        sh      <= tdr;
                        sda_low <= ~tdr[DW-1];
                        cnt     <= '0;
                        state   <= ST_SETUP;
                    end else if (rel_req) begin
                        state   <= ST_WSTOP;
                    end
                end
                ST_SETUP: state <= ST_TXBIT;
                ST_TXBIT: begin
                    if (scl_fall) begin
                        if (cnt == CW'(DW - 1)) begin
                            sda_low <= 1'b0;
                            state   <= ST_TXACK;
                        end else begin
                            cnt     <= cnt + 1'b1;
                            sh      <= {sh[DW-2:0], 1'b0};
                            sda_low <= ~sh[DW-2];
                        end
                    end
                end
                ST_TXACK: begin
                    if (scl_rise) begin
                        mack <= ~sda_s;
                    end else if (scl_fall) begin
                        if (load) begin
                            sh      <= tdr;
                            sda_low <= ~tdr[DW-1];
                            cnt     <= '0;
                            state   <= ST_SETUP;
                        end else begin
                            state   <= ST_STRETCH;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assert_sda_moves_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n || !enable)
        (scl_s && $past(scl_s)) |-> $stable(sda_low));
    assert_hold_starts_low_R6: assert property (@(posedge clk) disable iff (!rst_n || !enable)
        $rose(scl_low) |-> !scl_s);
    assert_load_needs_data_R5: assert property (@(posedge clk) disable iff (!rst_n || !enable)
        load |-> (!tdre && trs));
    assert_release_by_read_R8: assert property (@(posedge clk) disable iff (!rst_n || !enable)
        ((state == ST_WSTOP) && ($past(state) == ST_STRETCH)) |-> $past(rel_req));
    assert_wait_stop_free_R9: assert property (@(posedge clk) disable iff (!rst_n || !enable)
        (state == ST_WSTOP) |-> (!sda_low && !scl_low));
endmodule

// File: rtl/i2c_tgt_tx.sv
// Module: top of the I2C target read-data transmitter.
// What it does: ties the synchronizer, register block and bit engine
//   together and exposes open-drain pull-low enables for SCL and SDA.
// Assumes: the pads outside turn scl_oe/sda_oe into a low drive and feed
//   the resolved line levels back on scl_i/sda_i.
module i2c_tgt_tx #(
    parameter int DW     = 8,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [DW-2:0] own_addr,
    input  logic          ack_level,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          scl_oe,
    output logic          sda_oe,
    input  logic          wr_tdr,
    input  logic [DW-1:0] wr_data,
    input  logic          clr_tdre,
    input  logic          clr_tend,
    input  logic          clr_trs,
    input  logic          rd_rdr,
    output logic [DW-1:0] rdr_data,
    output logic          tdre,
    output logic          tend,
    output logic          trs
);
    logic          scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic          go_tx, load, byte_done, addr_cap, rel_req;
    logic [DW-1:0] addr_byte, tdr;

    i2c_tgt_sync #(.STAGES(STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .bus_start(bus_start), .bus_stop(bus_stop)
    );

    i2c_tgt_regs #(.DW(DW)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_tdr(wr_tdr), .wr_data(wr_data),
        .clr_tdre(clr_tdre), .clr_tend(clr_tend), .clr_trs(clr_trs), .rd_rdr(rd_rdr),
        .go_tx(go_tx), .load(load), .byte_done(byte_done), .addr_cap(addr_cap),
        .addr_byte(addr_byte), .tdr(tdr), .rdr(rdr_data), .tdre(tdre),
        .tend(tend), .trs(trs), .rel_req(rel_req)
    );

    i2c_tgt_fsm #(.DW(DW)) fsm_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .own_addr(own_addr),
        .ack_level(ack_level), .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop),
        .tdr(tdr), .tdre(tdre), .trs(trs), .rel_req(rel_req), .go_tx(go_tx),
        .load(load), .byte_done(byte_done), .addr_cap(addr_cap),
        .addr_byte(addr_byte), .scl_low(scl_oe), .sda_low(sda_oe)
    );
endmodule

// File: tb/i2c_tgt_tx_tb_top.sv
`timescale 1ns/1ps
// Bench: bus-master model plus host driver; a scoreboard queue holds the
// bytes the host wrote, and a monitor compares each byte the master reads.
module i2c_tgt_tx_tb_top;
    localparam int T = 16;

    logic       clk = 1'b0;
    logic       rst_n, enable, ack_level;
    logic [6:0] own_addr;
    logic       m_scl_low, m_sda_low;
    logic       scl_bus, sda_bus;
    logic       scl_oe, sda_oe;
    logic       wr_tdr, clr_tdre, clr_tend, clr_trs, rd_rdr;
    logic [7:0] wr_data, rdr_data;
    logic       tdre, tend, trs;
    logic       collide;
    logic       ack_seen;
    logic [7:0] got_byte, rx_b;
    logic [7:0] exp_q[$];
    event       byte_ev;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    assign scl_bus = !(m_scl_low || scl_oe);
    assign sda_bus = !(m_sda_low || sda_oe);

    i2c_tgt_tx dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .own_addr(own_addr),
        .ack_level(ack_level), .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .wr_tdr(wr_tdr), .wr_data(wr_data),
        .clr_tdre(clr_tdre), .clr_tend(clr_tend), .clr_trs(clr_trs),
        .rd_rdr(rd_rdr), .rdr_data(rdr_data), .tdre(tdre), .tend(tend), .trs(trs)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_hi();
        while (scl_bus !== 1'b1) @(negedge clk);
    endtask

    task automatic m_start();
        m_sda_low = 1'b1; ticks(T);
        m_scl_low = 1'b1; ticks(T);
    endtask

    task automatic m_stop();
        m_sda_low = 1'b1; ticks(T);
        m_scl_low = 1'b0; wait_hi(); ticks(T);
        m_sda_low = 1'b0; ticks(T);
    endtask

    task automatic m_send(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda_low = !b[i]; ticks(T);
            m_scl_low = 1'b0; wait_hi(); ticks(T);
            m_scl_low = 1'b1; ticks(T);
        end
        m_sda_low = 1'b0; ticks(T);
        m_scl_low = 1'b0; wait_hi(); ticks(T/2);
        ack = sda_bus; ticks(T/2);
        m_scl_low = 1'b1; ticks(T);
    endtask

    task automatic m_recv(input logic nack);
        logic [7:0] b;
        for (int i = 7; i >= 0; i--) begin
            m_sda_low = 1'b0; ticks(T);
            m_scl_low = 1'b0; wait_hi(); ticks(T/2);
            b[i] = sda_bus; ticks(T/2);
            m_scl_low = 1'b1; ticks(T);
        end
        m_sda_low = !nack; ticks(T);
        m_scl_low = 1'b0; wait_hi(); ticks(T);
        m_scl_low = 1'b1;
        if (collide) begin
            // Two sync stages plus the edge register: set lands on 3rd edge.
            ticks(2); clr_tend = 1'b1;
            ticks(1); clr_tend = 1'b0;
            ticks(T - 3);
        end else begin
            ticks(T);
        end
        m_sda_low = 1'b0;
        got_byte = b;
        -> byte_ev;
    endtask

    task automatic host_write(input logic [7:0] b);
        while (!tdre) @(negedge clk);
        exp_q.push_back(b);
        wr_data = b; wr_tdr = 1'b1;
        @(negedge clk); wr_tdr = 1'b0;
    endtask

    // Scoreboard monitor: compare each master-read byte with the queue head.
    always begin
        @(byte_ev);
        if (exp_q.size() == 0) chk("R4 unexpected byte", got_byte, 32'hFFFF);
        else                   chk("R4 byte MSB first", got_byte, exp_q.pop_front());
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; enable = 1'b1; ack_level = 1'b0; own_addr = 7'h3A;
        m_scl_low = 1'b0; m_sda_low = 1'b0; collide = 1'b0;
        wr_tdr = 1'b0; wr_data = '0; clr_tdre = 1'b0; clr_tend = 1'b0;
        clr_trs = 1'b0; rd_rdr = 1'b0;
        ticks(5);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 tdre", tdre, 0); chk("R1 tend", tend, 0); chk("R1 trs", trs, 0);
        chk("R1 scl_oe", scl_oe, 0); chk("R1 sda_oe", sda_oe, 0);
        ticks(5);

        // Mismatching address: no acknowledge, no transmit mode.
        m_start(); m_send({7'h55, 1'b1}, ack_seen);
        chk("R2 mismatch nack", ack_seen, 1); chk("R3 mismatch trs", trs, 0);
        m_stop();

        // Matching write address: acknowledged, but stays out of transmit.
        m_start(); m_send({7'h3A, 1'b0}, ack_seen);
        chk("R2 match ack", ack_seen, 0); chk("R3 write trs", trs, 0);
        m_stop();

        // Acknowledge level programmed to 1: released, no transmit mode.
        ack_level = 1'b1;
        m_start(); m_send({7'h3A, 1'b1}, ack_seen);
        chk("R2 ack_level nack", ack_seen, 1); chk("R3 nack trs", trs, 0);
        m_stop();
        ack_level = 1'b0;

        // Read transfer of four bytes.
        m_start(); m_send({7'h3A, 1'b1}, ack_seen);
        chk("R2 read ack", ack_seen, 0);
        chk("R3 trs set", trs, 1); chk("R3 tdre set", tdre, 1);
        m_scl_low = 1'b0; ticks(60);
        chk("R6 held while empty", scl_bus, 0);
        host_write(8'hA5);
        chk("R5 write clears tdre", tdre, 0);
        ticks(4);
        chk("R5 load sets tdre", tdre, 1);
        ticks(4);
        chk("R6 released after write", scl_bus, 1);
        fork m_recv(1'b0); host_write(8'h3C); join
        fork m_recv(1'b0); host_write(8'h80); join
        fork m_recv(1'b0); host_write(8'h01); join
        collide = 1'b1; m_recv(1'b1); collide = 1'b0;
        chk("R7 set wins over clear", tend, 1);
        chk("R9 sda released after nack", sda_oe, 0);
        m_sda_low = 1'b1; m_scl_low = 1'b0; ticks(40);
        chk("R8 held after last byte", scl_bus, 0);
        clr_tend = 1'b1; ticks(1); clr_tend = 1'b0; ticks(1);
        chk("R7 clear", tend, 0);
        rd_rdr = 1'b1; ticks(1); rd_rdr = 1'b0; ticks(20);
        chk("R8 read with trs=1 holds", scl_bus, 0);
        chk("R8 rdr address byte", rdr_data, 8'h75);
        clr_trs = 1'b1; ticks(1); clr_trs = 1'b0; ticks(20);
        chk("R8 clr_trs alone holds", scl_bus, 0);
        rd_rdr = 1'b1; ticks(1); rd_rdr = 1'b0; ticks(6);
        chk("R8 dummy read releases", scl_bus, 1);
        wait_hi(); ticks(T); m_sda_low = 1'b0; ticks(T);
        chk("R5 tdre before clear", tdre, 1);
        clr_tdre = 1'b1; ticks(1); clr_tdre = 1'b0; ticks(1);
        chk("R5 clr_tdre", tdre, 0);
        chk("R4 queue drained", exp_q.size(), 0);

        // After the stop, a new start is decoded again.
        m_start(); m_send({7'h3A, 1'b1}, ack_seen);
        chk("R9 re-address ack", ack_seen, 0); chk("R9 re-address trs", trs, 1);
        m_scl_low = 1'b0; m_sda_low = 1'b1; ticks(20);
        clr_trs = 1'b1; ticks(1); clr_trs = 1'b0;
        rd_rdr = 1'b1; ticks(1); rd_rdr = 1'b0; ticks(6);
        chk("R8 release without data", scl_bus, 1);
        wait_hi(); ticks(T); m_sda_low = 1'b0; ticks(T);
        clr_tdre = 1'b1; ticks(1); clr_tdre = 1'b0; ticks(4);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule